// File: doc/BRIEF.md
# Message-Signalled Interrupt File

This block holds the interrupt state of one privilege level on one hart when interrupts arrive as memory writes. Each interrupt identity has a pending bit and an enable bit. A device raises an identity by writing its number to the set-pending message port. Software reads and updates the pending and enable arrays one XLEN-wide word at a time through a register port. The same register port gives access to a delivery switch, a priority threshold and a claim register. The claim register reports the best eligible identity, and a read-with-write on it retires that identity.

The search always favours the lowest identity number that is pending, enabled and below the threshold. When delivery is on and such an identity exists, the block drives a level-sensitive external interrupt to the hart. If an update occurs while the line is high, the line drops for one cycle and then rises again if there is still work. A second interrupt therefore reaches the hart as a fresh edge.

Both ports are valid/ready. `msg_ready` and `reg_ready` are tied high, because every request completes in the cycle it is presented and the block never applies back-pressure. `reg_rdata` is combinational. It is valid in the same cycle as `reg_valid` and reflects the state before that cycle's update.

Top module: `msi_intfile`

## Requirements
- R1: Identity 0 and all identities at or above NUM_IDS are unimplemented. Their pending and enable bits always read 0. A set-pending message carrying 0 or any value of NUM_IDS or more changes nothing.
- R2: The top identity is the lowest-numbered identity, 1 or higher, whose pending and enable bits are both 1.
- R3: A threshold T limits the search only when T is nonzero and T <= NUM_IDS. In that case only identities strictly below T qualify. Otherwise every implemented identity qualifies.
- R4: Reading the claim register (reg_sel=4) returns (id << 16) | id for the top identity id. It returns 0 when no identity qualifies.
- R5: An accepted message (msg_valid) with a value v where 0 < v < NUM_IDS sets the pending bit of identity v. The pending bit reads back as 1 from the next cycle.
- R6: An access to reg_sel=4 with reg_wr=1 clears the pending bit of the identity it returns, if that identity is nonzero. If a message sets that same identity in the same cycle, the set wins and the bit stays 1. A set of a different identity in that cycle is also applied.
- R7: reg_sel=0 selects the pending array and reg_sel=1 selects the enable array. Word k covers identities k*XLEN to k*XLEN+XLEN-1, with identity k*XLEN+b at bit b. The access returns the word as it was before the update. With reg_wr=1, only bits whose reg_wmask bit is 1 take the matching reg_wdata bit.
- R8: reg_sel=2 is the delivery register and reg_sel=3 is the threshold register. Both are written under reg_wmask. eip_o is 1, one cycle after the state settles, exactly when the delivery register is nonzero and a top identity exists.
- R9: If eip_o is 1 when an update occurs, eip_o is 0 in the next cycle and returns one cycle later if the condition still holds. An update is an accepted message with a valid value, or any access to reg_sel 0, 1 or 4.
- R10: After reset, all pending bits, all enable bits, the threshold and the delivery register are 0, and eip_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Set-pending message valid |
| msg_ready | output | 1 | Always 1 |
| msg_data | input | XLEN | Identity number to mark pending |
| reg_valid | input | 1 | Register access valid |
| reg_ready | output | 1 | Always 1 |
| reg_sel | input | 3 | 0 pending, 1 enable, 2 delivery, 3 threshold, 4 claim |
| reg_idx | input | IDX_W | Word index for array accesses |
| reg_wr | input | 1 | Access also writes |
| reg_wdata | input | XLEN | New value |
| reg_wmask | input | XLEN | Bits to update |
| reg_rdata | output | XLEN | Value before update, same cycle |
| eip_o | output | 1 | External interrupt to the hart |

## Verification
The assertions assume that reg_sel carries only codes 0 to 4 and that reg_idx stays below the number of array words. They also assume that reset is held for at least one clock edge before the first request. The bench drives only legal select codes and word indices, and it changes inputs only just after a clock edge. Out-of-range identities reach the block only through the message data, where R1 requires them to be ignored.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [2:0] {
    SEL_PEND   = 3'd0,
    SEL_ENAB   = 3'd1,
    SEL_DELIV  = 3'd2,
    SEL_THRESH = 3'd3,
    SEL_CLAIM  = 3'd4
  } msi_sel_e;

  localparam int unsigned ID_SHIFT = 16;
endpackage

// File: rtl/msi_bit_array.sv
module msi_bit_array #(
  parameter int unsigned NBITS   = 64,
  parameter int unsigned XLEN    = 32,
  parameter int unsigned NUM_IDS = 63,
  parameter int unsigned IDX_W   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic             acc_wr,
  input  logic [XLEN-1:0]  acc_wdata,
  input  logic [XLEN-1:0]  acc_wmask,
  input  logic [NBITS-1:0] set_vec,
  input  logic [NBITS-1:0] clr_vec,
  output logic [NBITS-1:0] bits_o,
  output logic [XLEN-1:0]  rdata_o
);
  localparam int unsigned WORDS = NBITS / XLEN;

  logic [NBITS-1:0] impl;
  logic [NBITS-1:0] bits_q, bits_d;

  for (genvar i = 0; i < NBITS; i++) begin : g_impl
    assign impl[i] = (i >= 1) && (i < NUM_IDS);
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (acc_idx == IDX_W'(w)) rdata_o = bits_q[w*XLEN +: XLEN];
    end
  end

  always_comb begin
    bits_d = bits_q;
    if (acc_en && acc_wr) begin
      for (int w = 0; w < WORDS; w++) begin
        if (acc_idx == IDX_W'(w))
          bits_d[w*XLEN +: XLEN] = (bits_q[w*XLEN +: XLEN] & ~acc_wmask) |
                                   (acc_wdata & acc_wmask);
      end
    end
    bits_d = ((bits_d & ~clr_vec) | set_vec) & impl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= bits_d;
  end

  assign bits_o = bits_q;

  // R7: a write with a full mask and no side vectors lands exactly
  a_r7_full_write: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && acc_wmask == '1 && acc_wdata == '0 &&
     set_vec == '0) |=> (rdata_o == '0 || acc_idx != $past(acc_idx)));
endmodule

// File: rtl/msi_prio_enc.sv
module msi_prio_enc #(
  parameter int unsigned NBITS = 64,
  parameter int unsigned ID_W  = 6
) (
  input  logic [NBITS-1:0] vec_i,
  output logic [ID_W-1:0]  id_o,
  output logic             hit_o
);
  always_comb begin
    id_o  = '0;
    hit_o = 1'b0;
    for (int i = NBITS - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        id_o  = ID_W'(i);
        hit_o = 1'b1;
      end
    end
  end

  // R2: a hit always names a set bit
  always_comb begin
    a_r2_hit_is_set: assert (!hit_o || vec_i[id_o]);
  end
endmodule

// File: rtl/msi_eip_gen.sv
module msi_eip_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic want_i,
  input  logic upd_i,
  output logic eip_o
);
  logic eip_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              eip_q <= 1'b0;
    else if (upd_i && eip_q) eip_q <= 1'b0;
    else                     eip_q <= want_i;
  end

  assign eip_o = eip_q;

  // R9: an update seen while high forces a low cycle
  a_r9_drop_on_update: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && eip_q) |=> !eip_q);

  // R8: the line rises only when the condition held a cycle earlier
  a_r8_rise_needs_want: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eip_q) |-> $past(want_i));
endmodule

// File: rtl/msi_intfile.sv
module msi_intfile
  import msi_pkg::*;
#(
  parameter int unsigned NUM_IDS = 63,
  parameter int unsigned XLEN    = 32,
  localparam int unsigned WORDS  = (NUM_IDS + XLEN) / XLEN,
  localparam int unsigned NBITS  = WORDS * XLEN,
  localparam int unsigned ID_W   = $clog2(NBITS),
  localparam int unsigned IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  output logic             msg_ready,
  input  logic [XLEN-1:0]  msg_data,
  input  logic             reg_valid,
  output logic             reg_ready,
  input  logic [2:0]       reg_sel,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic             reg_wr,
  input  logic [XLEN-1:0]  reg_wdata,
  input  logic [XLEN-1:0]  reg_wmask,
  output logic [XLEN-1:0]  reg_rdata,
  output logic             eip_o
);
  logic             pend_acc, enab_acc, claim_acc, claim;
  logic             msg_ok;
  logic [ID_W-1:0]  msg_id;
  logic [NBITS-1:0] set_vec, clr_vec, zero_vec;
  logic [NBITS-1:0] pend_bits, enab_bits, elig;
  logic [XLEN-1:0]  pend_rd, enab_rd;
  logic [XLEN-1:0]  deliv_q, thr_q, lim, top_word;
  logic [ID_W-1:0]  top_id;
  logic             top_hit, upd, want;

  assign msg_ready = 1'b1;
  assign reg_ready = 1'b1;
  assign zero_vec  = '0;

  assign pend_acc  = reg_valid && (reg_sel == SEL_PEND);
  assign enab_acc  = reg_valid && (reg_sel == SEL_ENAB);
  assign claim_acc = reg_valid && (reg_sel == SEL_CLAIM);
  assign claim     = claim_acc && reg_wr && top_hit;

  assign msg_ok  = msg_valid && (msg_data != '0) && (msg_data < XLEN'(NUM_IDS));
  assign msg_id  = msg_data[ID_W-1:0];
  assign set_vec = msg_ok ? (NBITS'(1) << msg_id) : '0;
  assign clr_vec = claim  ? (NBITS'(1) << top_id) : '0;

  msi_bit_array #(.NBITS(NBITS), .XLEN(XLEN), .NUM_IDS(NUM_IDS), .IDX_W(IDX_W))
  u_pend (
    .clk(clk), .rst_n(rst_n), .acc_en(pend_acc), .acc_idx(reg_idx),
    .acc_wr(reg_wr), .acc_wdata(reg_wdata), .acc_wmask(reg_wmask),
    .set_vec(set_vec), .clr_vec(clr_vec), .bits_o(pend_bits), .rdata_o(pend_rd)
  );

  msi_bit_array #(.NBITS(NBITS), .XLEN(XLEN), .NUM_IDS(NUM_IDS), .IDX_W(IDX_W))
  u_enab (
    .clk(clk), .rst_n(rst_n), .acc_en(enab_acc), .acc_idx(reg_idx),
    .acc_wr(reg_wr), .acc_wdata(reg_wdata), .acc_wmask(reg_wmask),
    .set_vec(zero_vec), .clr_vec(zero_vec), .bits_o(enab_bits), .rdata_o(enab_rd)
  );

  // threshold window: active only when nonzero and within the identity range
  assign lim = ((thr_q != '0) && (thr_q <= XLEN'(NUM_IDS))) ? thr_q : XLEN'(NUM_IDS);

  for (genvar i = 0; i < NBITS; i++) begin : g_elig
    assign elig[i] = pend_bits[i] && enab_bits[i] && (XLEN'(i) < lim);
  end

  msi_prio_enc #(.NBITS(NBITS), .ID_W(ID_W)) u_prio (
    .vec_i(elig), .id_o(top_id), .hit_o(top_hit)
  );

  assign top_word = top_hit ?
    ((XLEN'(top_id) << ID_SHIFT) | XLEN'(top_id)) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      deliv_q <= '0;
      thr_q   <= '0;
    end else if (reg_valid && reg_wr) begin
      if (reg_sel == SEL_DELIV)
        deliv_q <= (deliv_q & ~reg_wmask) | (reg_wdata & reg_wmask);
      if (reg_sel == SEL_THRESH)
        thr_q <= (thr_q & ~reg_wmask) | (reg_wdata & reg_wmask);
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_PEND:   reg_rdata = pend_rd;
      SEL_ENAB:   reg_rdata = enab_rd;
      SEL_DELIV:  reg_rdata = deliv_q;
      SEL_THRESH: reg_rdata = thr_q;
      SEL_CLAIM:  reg_rdata = top_word;
      default:    reg_rdata = '0;
    endcase
  end

  assign upd  = msg_ok || pend_acc || enab_acc || claim_acc;
  assign want = (deliv_q != '0) && top_hit;

  msi_eip_gen u_eip (
    .clk(clk), .rst_n(rst_n), .want_i(want), .upd_i(upd), .eip_o(eip_o)
  );

  // R5: a valid message leaves its identity pending
  a_r5_set_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_ok && !pend_acc) |=> pend_bits[$past(msg_id)]);

  // R6: a claim retires its identity unless the same identity is set
  a_r6_claim_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && !(msg_ok && msg_id == top_id)) |=> !pend_bits[$past(top_id)]);

  // R1: identity 0 never wins the search
  always_comb begin
    a_r1_zero_never_top: assert (!top_hit || top_id != '0);
  end

  // R3: a winner lies below an active threshold
  always_comb begin
    a_r3_below_limit: assert (!top_hit || XLEN'(top_id) < lim);
  end
endmodule

// File: tb/msi_intfile_bench.sv
module msi_intfile_bench;
  localparam int unsigned XLEN = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_valid = 1'b0;
  logic        msg_ready;
  logic [31:0] msg_data = '0;
  logic        reg_valid = 1'b0;
  logic        reg_ready;
  logic [2:0]  reg_sel = '0;
  logic [0:0]  reg_idx = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_wmask = '0;
  logic [31:0] reg_rdata;
  logic        eip_o;

  int total = 0;
  int bad = 0;
  logic [31:0] rd;

  always #5 clk = ~clk;

  msi_intfile u_msi_intfile (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_data(msg_data), .reg_valid(reg_valid), .reg_ready(reg_ready),
    .reg_sel(reg_sel), .reg_idx(reg_idx), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_wmask(reg_wmask), .reg_rdata(reg_rdata),
    .eip_o(eip_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic reg_op(input logic [2:0] sel, input logic idx, input logic wr,
                        input logic [31:0] wd, input logic [31:0] wm,
                        output logic [31:0] r);
    @(negedge clk);
    reg_valid = 1'b1; reg_sel = sel; reg_idx = idx; reg_wr = wr;
    reg_wdata = wd; reg_wmask = wm;
    #1 r = reg_rdata;
    @(posedge clk); #1;
    reg_valid = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic send(input logic [31:0] v);
    @(negedge clk);
    msg_valid = 1'b1; msg_data = v;
    @(posedge clk); #1;
    msg_valid = 1'b0;
  endtask

  task automatic send_and_claim(input logic [31:0] v, output logic [31:0] r);
    @(negedge clk);
    msg_valid = 1'b1; msg_data = v;
    reg_valid = 1'b1; reg_sel = 3'd4; reg_idx = '0; reg_wr = 1'b1;
    reg_wdata = '0; reg_wmask = '0;
    #1 r = reg_rdata;
    @(posedge clk); #1;
    msg_valid = 1'b0; reg_valid = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    chk("R10 eip after reset", 32'(eip_o), 0);
    reg_op(3'd4, 0, 0, 0, 0, rd); chk("R10 claim reads zero", rd, 0);
    reg_op(3'd0, 0, 0, 0, 0, rd); chk("R10 pending clear", rd, 0);
    reg_op(3'd1, 1, 0, 0, 0, rd); chk("R10 enable clear", rd, 0);
    reg_op(3'd3, 0, 0, 0, 0, rd); chk("R10 threshold clear", rd, 0);
    chk("R10 msg_ready high", 32'(msg_ready & reg_ready), 1);
  endtask

  task automatic t_enable_words;
    reg_op(3'd1, 0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, rd);
    chk("R7 returns prior word", rd, 0);
    reg_op(3'd1, 0, 0, 0, 0, rd); chk("R1 enable bit0 stays 0", rd, 32'hFFFF_FFFE);
    reg_op(3'd1, 1, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, rd);
    reg_op(3'd1, 1, 0, 0, 0, rd); chk("R1 enable id63 stays 0", rd, 32'h7FFF_FFFF);
    reg_op(3'd1, 1, 1, 32'h0, 32'h0000_00F0, rd);
    chk("R7 old value on masked write", rd, 32'h7FFF_FFFF);
    reg_op(3'd1, 1, 0, 0, 0, rd); chk("R7 only masked bits change", rd, 32'h7FFF_FF0F);
  endtask

  task automatic t_set_pending;
    send(5);
    reg_op(3'd0, 0, 0, 0, 0, rd); chk("R5 id5 pending", rd, 32'h20);
    reg_op(3'd4, 0, 0, 0, 0, rd); chk("R4 claim encoding", rd, 32'h0005_0005);
    wait_cyc(2); chk("R8 no delivery no eip", 32'(eip_o), 0);
  endtask

  task automatic t_ignored;
    send(0); send(63); send(1000);
    reg_op(3'd0, 0, 0, 0, 0, rd); chk("R1 word0 unchanged", rd, 32'h20);
    reg_op(3'd0, 1, 0, 0, 0, rd); chk("R1 word1 unchanged", rd, 0);
  endtask

  task automatic t_delivery;
    reg_op(3'd2, 0, 1, 1, 32'hFFFF_FFFF, rd);
    wait_cyc(2); chk("R8 eip with delivery", 32'(eip_o), 1);
  endtask

  task automatic t_priority_threshold;
    send(40); send(3);
    reg_op(3'd4, 0, 0, 0, 0, rd); chk("R2 lowest wins", rd, 32'h0003_0003);
    reg_op(3'd3, 0, 1, 3, 32'hFFFF_FFFF, rd);
    reg_op(3'd4, 0, 0, 0, 0, rd); chk("R3 threshold 3 blocks", rd, 0);
    wait_cyc(2); chk("R8 eip low when none qualify", 32'(eip_o), 0);
    reg_op(3'd3, 0, 1, 4, 32'hFFFF_FFFF, rd);
    reg_op(3'd4, 0, 0, 0, 0, rd); chk("R3 threshold 4 admits 3", rd, 32'h0003_0003);
    reg_op(3'd3, 0, 1, 0, 32'hFFFF_FFFF, rd);
  endtask

  task automatic t_pulse;
    wait_cyc(2); chk("R8 eip settled high", 32'(eip_o), 1);
    send(7);
    chk("R9 eip dropped after update", 32'(eip_o), 0);
    wait_cyc(1); chk("R9 eip raised again", 32'(eip_o), 1);
  endtask

  task automatic t_claim;
    reg_op(3'd4, 0, 1, 0, 0, rd); chk("R6 claim returns top", rd, 32'h0003_0003);
    reg_op(3'd4, 0, 0, 0, 0, rd); chk("R6 next top after claim", rd, 32'h0005_0005);
    reg_op(3'd0, 0, 0, 0, 0, rd); chk("R6 id3 cleared", rd, 32'hA0);
    send_and_claim(5, rd); chk("R6 claim value same-cycle", rd, 32'h0005_0005);
    reg_op(3'd0, 0, 0, 0, 0, rd); chk("R6 set wins same id", rd, 32'hA0);
    send_and_claim(9, rd);
    reg_op(3'd0, 0, 0, 0, 0, rd); chk("R6 other id set, top cleared", rd, 32'h280);
  endtask

  task automatic t_array_edits;
    reg_op(3'd1, 0, 1, 0, 32'h80, rd); chk("R7 enable old value", rd, 32'hFFFF_FFFE);
    reg_op(3'd4, 0, 0, 0, 0, rd); chk("R2 disabled id skipped", rd, 32'h0009_0009);
    reg_op(3'd0, 0, 1, 0, 32'hFFFF_FFFF, rd); chk("R7 pending old value", rd, 32'h280);
    reg_op(3'd0, 1, 0, 0, 0, rd); chk("R7 word1 holds id40", rd, 32'h100);
    reg_op(3'd4, 0, 0, 0, 0, rd); chk("R2 id40 top", rd, 32'h0028_0028);
    reg_op(3'd3, 0, 1, 40, 32'hFFFF_FFFF, rd);
    reg_op(3'd4, 0, 0, 0, 0, rd); chk("R3 strictly below threshold", rd, 0);
    reg_op(3'd3, 0, 1, 41, 32'hFFFF_FFFF, rd);
    reg_op(3'd4, 0, 0, 0, 0, rd); chk("R3 threshold 41", rd, 32'h0028_0028);
    reg_op(3'd3, 0, 1, 1000, 32'hFFFF_FFFF, rd);
    reg_op(3'd4, 0, 0, 0, 0, rd); chk("R3 out-of-range threshold unlimited", rd, 32'h0028_0028);
  endtask

  task automatic t_delivery_off;
    reg_op(3'd2, 0, 1, 0, 32'hFFFF_FFFF, rd);
    wait_cyc(2); chk("R8 delivery off drops eip", 32'(eip_o), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    t_reset();
    t_enable_words();
    t_set_pending();
    t_ignored();
    t_delivery();
    t_priority_threshold();
    t_pulse();
    t_claim();
    t_array_edits();
    t_delivery_off();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule